// File: doc/BRIEF.md
# Effective Address Modification Unit

This block resolves the operand address of a 24-bit instruction word before execution. The word is split into a 6-bit opcode (bits 23-18), a 3-bit index selector (bits 17-15), an indirect flag (bit 14) and a 14-bit address (bits 13-0). For each round, the unit first applies index-register addition. If the indirect flag is set, it then fetches a word from memory whose low bits replace those of the held instruction. The fetched word's own selector and indirect flag drive the next round, and chains of any length are followed.

The unit reads an eight-entry, 14-bit index register file through a combinational read port (select out, value in). It fetches indirect words through a request/acknowledge memory read port. Opcodes that use bits 17-14 as a condition field pass through untouched. The two index-transfer opcodes treat bits 17-15 as a register number, so they skip indexing and keep that field across indirection. When the chain ends, the unit raises `done` and holds the final word and the effective address until the next `start`.

Top module: `eff_addr_unit`

## Requirements
- R1: After reset, `done` and `mem_req` are low.
- R2: When the selector in bits 17-15 is nonzero, the selected index register is added to bits 13-0 modulo 2^14, and bits 17-15 of the held word become 0.
- R3: A selector of 0 performs no addition; register 0 never takes part in address modification.
- R4: Within a round, indexing is done before indirection, so the memory fetch uses the indexed address.
- R5: On indirection, bits 17-0 of the fetched word replace bits 17-0 of the held word and a new round starts; bits 23-18 of the fetched word are ignored; chains of several levels are followed.
- R6: The condition-field opcodes (defaults octal 40, 41, 42) complete with the word unchanged and issue no memory request.
- R7: The index-transfer opcodes (defaults octal 05 and 13) are never indexed. On indirection, only bits 14-0 are taken from memory, and bits 17-15 keep their value.
- R8: `done` rises with a final word whose bit 14 is 0 (condition-field opcodes excepted), `eff_addr` equals bits 13-0 of `instr_out`, and both hold unchanged until the next `start`.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen; the opcode bits 23-18 of the held word never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin resolving `instr_in` (accepted when idle or done) |
| instr_in | input | 24 | Instruction word to resolve |
| xr_sel | output | 3 | Index register file read select |
| xr_data | input | 14 | Index register value for `xr_sel` |
| mem_req | output | 1 | Indirect word fetch request |
| mem_addr | output | 14 | Indirect word address |
| mem_ack | input | 1 | Fetch response valid |
| mem_rdata | input | 24 | Fetched indirect word |
| done | output | 1 | Resolution complete, outputs valid |
| instr_out | output | 24 | Modified instruction word |
| eff_addr | output | 14 | Effective operand address |

## Verification
The hardest case to reach is a multi-level chain in which an intermediate fetched word brings in its own nonzero selector and its own indirect flag. The next fetch address must then include that second addition. The bench loads a small memory model so that the first indirect word names index register 5 with the indirect flag set, and the second names register 2 without it. It slows acknowledges by several cycles and compares the logged fetch addresses and the final word against values worked out by hand. Index-transfer indirection is driven with a fetched word whose bits 17-15 differ from the instruction's, to show that those bits are kept.

// File: rtl/eau_pkg.sv
// Package: shared widths, field positions and controller states for the
// effective address modification unit. Assumes the 24-bit word layout
// opcode[23:18], selector[17:15], indirect[14], address[13:0].
package eau_pkg;
    localparam int WORD_W = 24;
    localparam int ADDR_W = 14;
    localparam int SEL_W  = 3;
    localparam int OP_W   = 6;
    localparam int IND_BIT = ADDR_W;
    localparam int SEL_LO  = ADDR_W + 1;
    localparam int SEL_HI  = SEL_LO + SEL_W - 1;
    localparam int OP_LO   = SEL_HI + 1;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_EVAL  = 2'd1,
        S_FETCH = 2'd2,
        S_DONE  = 2'd3
    } eau_state_t;
endpackage

// File: rtl/eau_opclass.sv
// Opcode classifier: flags opcodes whose bits 17-14 are a condition field
// (no modification at all) and opcodes whose selector names an index
// register (no indexing, selector kept through indirection).
// Assumes the opcode lists are given as parameters.
module eau_opclass #(
    parameter int OP_W = 6,
    parameter int N_BYP = 3,
    parameter int N_XFR = 2,
    parameter logic [N_BYP*OP_W-1:0] BYP_OPS = {6'o42, 6'o41, 6'o40},
    parameter logic [N_XFR*OP_W-1:0] XFR_OPS = {6'o13, 6'o05}
) (
    input  logic [OP_W-1:0] op,
    output logic            bypass,
    output logic            xfer
);
    logic [N_BYP-1:0] byp_hit;
    logic [N_XFR-1:0] xfr_hit;

    // one comparator per condition-field opcode
    for (genvar i = 0; i < N_BYP; i++) begin : g_byp
        assign byp_hit[i] = (op == BYP_OPS[i*OP_W +: OP_W]);
    end
    // one comparator per index-transfer opcode
    for (genvar j = 0; j < N_XFR; j++) begin : g_xfr
        assign xfr_hit[j] = (op == XFR_OPS[j*OP_W +: OP_W]);
    end

    assign bypass = |byp_hit;
    assign xfer   = |xfr_hit;
endmodule

// File: rtl/eau_index_add.sv
// Index stage: when enabled, adds the index register value to the address
// field (wrapping at the address width) and clears the selector field.
// Assumes the caller has already excluded selector 0 and exempt opcodes.
module eau_index_add #(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 14,
    parameter int SEL_W  = 3
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              en,
    input  logic [ADDR_W-1:0] xval,
    output logic [WORD_W-1:0] word_out
);
    localparam int SEL_LO = ADDR_W + 1;
    localparam int UPPER  = WORD_W - SEL_LO - SEL_W;

    logic [ADDR_W-1:0] sum;

    // wrapping address addition
    always_comb sum = word_in[ADDR_W-1:0] + xval;

    // rebuild the word with sum and cleared selector when enabled
    always_comb begin
        if (en)
            word_out = {word_in[WORD_W-1 -: UPPER], {SEL_W{1'b0}},
                        word_in[ADDR_W], sum};
        else
            word_out = word_in;
    end
endmodule

// File: rtl/eau_merge.sv
// Indirect merge: overlays the low bits of a fetched word onto the held
// word. Normal opcodes take the selector, flag and address; index-transfer
// opcodes take only flag and address. Upper fetched bits are discarded.
module eau_merge #(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 14,
    parameter int SEL_W  = 3
) (
    input  logic [WORD_W-1:0] held,
    input  logic [WORD_W-1:0] fetched,
    input  logic              xfer,
    output logic [WORD_W-1:0] merged
);
    localparam int LOW_FULL = ADDR_W + 1 + SEL_W;
    localparam int LOW_XFR  = ADDR_W + 1;
    localparam logic [WORD_W-1:0] MASK_FULL = {{(WORD_W-LOW_FULL){1'b0}}, {LOW_FULL{1'b1}}};
    localparam logic [WORD_W-1:0] MASK_XFR  = {{(WORD_W-LOW_XFR){1'b0}}, {LOW_XFR{1'b1}}};

    logic [WORD_W-1:0] take;

    // choose which low bits come from memory
    always_comb take = xfer ? MASK_XFR : MASK_FULL;

    // bitwise overlay
    always_comb merged = (fetched & take) | (held & ~take);
endmodule

// File: rtl/eff_addr_unit.sv
// Top: effective address modification controller. Holds the instruction
// word and loops EVAL (index, then decide on indirection) and FETCH
// (indirect read) until the indirect flag is clear, then reports done.
// Assumes the index file read is combinational and memory answers with a
// one-cycle mem_ack pulse while mem_req is high.
module eff_addr_unit
    import eau_pkg::*;
#(
    parameter int N_BYP = 3,
    parameter int N_XFR = 2,
    parameter logic [N_BYP*OP_W-1:0] BYP_OPS = {6'o42, 6'o41, 6'o40},
    parameter logic [N_XFR*OP_W-1:0] XFR_OPS = {6'o13, 6'o05}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr_in,
    output logic [SEL_W-1:0]  xr_sel,
    input  logic [ADDR_W-1:0] xr_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [WORD_W-1:0] instr_out,
    output logic [ADDR_W-1:0] eff_addr
);
    eau_state_t        state;
    logic [WORD_W-1:0] word_q;
    logic              bypass;
    logic              xfer;
    logic              idx_en;
    logic [WORD_W-1:0] idx_word;
    logic [WORD_W-1:0] merged;

    eau_opclass #(
        .OP_W(OP_W), .N_BYP(N_BYP), .N_XFR(N_XFR),
        .BYP_OPS(BYP_OPS), .XFR_OPS(XFR_OPS)
    ) u_class (
        .op(word_q[WORD_W-1:OP_LO]), .bypass(bypass), .xfer(xfer)
    );

    // indexing allowed only for nonzero selector on ordinary opcodes
    always_comb idx_en = !bypass && !xfer && (word_q[SEL_HI:SEL_LO] != '0);

    eau_index_add #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_index (
        .word_in(word_q), .en(idx_en), .xval(xr_data), .word_out(idx_word)
    );

    eau_merge #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_merge (
        .held(word_q), .fetched(mem_rdata), .xfer(xfer), .merged(merged)
    );

    // controller state and held word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            word_q <= '0;
        end else begin
            case (state)
                S_IDLE, S_DONE: begin
                    if (start) begin
                        word_q <= instr_in;
                        state  <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    if (bypass) begin
                        state <= S_DONE;
                    end else begin
                        word_q <= idx_word;
                        state  <= idx_word[IND_BIT] ? S_FETCH : S_DONE;
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        word_q <= merged;
                        state  <= S_EVAL;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // output decode
    always_comb begin
        xr_sel    = word_q[SEL_HI:SEL_LO];
        mem_req   = (state == S_FETCH);
        mem_addr  = word_q[ADDR_W-1:0];
        done      = (state == S_DONE);
        instr_out = word_q;
        eff_addr  = word_q[ADDR_W-1:0];
    end

    // ---------------- assertions ----------------
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> !done && !mem_req);

    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr));

    a_r9_opcode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_DONE) |=>
            $stable(word_q[WORD_W-1:OP_LO]) || $past(start));

    a_r8_final_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!instr_out[IND_BIT] || bypass));

    a_r8_outputs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(instr_out) && $stable(eff_addr));

    a_r6_bypass_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EVAL && bypass) |=> done && !mem_req);

    a_r2_selector_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EVAL && idx_en) |=> word_q[SEL_HI:SEL_LO] == '0);
endmodule

// File: tb/eff_addr_unit_tb.sv
`timescale 1ns/1ps
module eff_addr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] instr_in = '0;
    logic [2:0]  xr_sel;
    logic [13:0] xr_data;
    logic        mem_req;
    logic [13:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [23:0] mem_rdata = '0;
    logic        done;
    logic [23:0] instr_out;
    logic [13:0] eff_addr;

    int checks = 0;
    int errors = 0;

    logic [13:0] xregs [8];
    logic [23:0] mem [64];
    logic [13:0] flog [8];
    int          fcount = 0;
    int          ack_delay = 0;
    int          wait_ctr = 0;
    logic        addr_moved = 1'b0;
    logic [13:0] first_addr = '0;

    always #2.5 clk = ~clk;

    eff_addr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_in(instr_in),
        .xr_sel(xr_sel), .xr_data(xr_data), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .instr_out(instr_out), .eff_addr(eff_addr)
    );

    always_comb xr_data = xregs[xr_sel];

    // memory model: answers at falling edges after ack_delay waiting cycles
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            if (wait_ctr == 0) first_addr = mem_addr;
            else if (mem_addr != first_addr) addr_moved = 1'b1;
            if (wait_ctr >= ack_delay) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[5:0]];
                if (fcount < 8) flog[fcount] = mem_addr;
                fcount = fcount + 1;
                wait_ctr = 0;
            end else begin
                wait_ctr = wait_ctr + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    function automatic logic [23:0] mk(input logic [5:0] op, input logic [2:0] x,
                                       input logic ind, input logic [13:0] a);
        return {op, x, ind, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [23:0] w);
        @(negedge clk);
        fcount = 0;
        instr_in = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_index;
        run(mk(6'o20, 3'd2, 1'b0, 14'h0403));
        check("R2 word", {8'd0, instr_out}, {8'd0, mk(6'o20, 3'd0, 1'b0, 14'h0413)});
        check("R8 eff_addr", {18'd0, eff_addr}, 32'h0413);
        check("R2 no fetch", fcount, 0);
        run(mk(6'o20, 3'd3, 1'b0, 14'h0005));
        check("R2 wrap", {8'd0, instr_out}, {8'd0, mk(6'o20, 3'd0, 1'b0, 14'h0004)});
    endtask

    task automatic t_noindex;
        run(mk(6'o24, 3'd0, 1'b0, 14'h0200));
        check("R3 sel0 unchanged", {8'd0, instr_out}, {8'd0, mk(6'o24, 3'd0, 1'b0, 14'h0200)});
    endtask

    task automatic t_ind_single;
        run(mk(6'o20, 3'd1, 1'b1, 14'h0020));
        check("R4 fetch count", fcount, 1);
        check("R4 fetch addr", {18'd0, flog[0]}, 32'h0021);
        check("R5 word", {8'd0, instr_out}, {8'd0, mk(6'o20, 3'd0, 1'b0, 14'h0130)});
    endtask

    task automatic t_chain;
        ack_delay = 3;
        addr_moved = 1'b0;
        run(mk(6'o24, 3'd0, 1'b1, 14'h0002));
        check("R5 chain fetches", fcount, 2);
        check("R5 first addr", {18'd0, flog[0]}, 32'h0002);
        check("R5 second addr", {18'd0, flog[1]}, 32'h0108);
        check("R5 chain word", {8'd0, instr_out}, {8'd0, mk(6'o24, 3'd0, 1'b0, 14'h0017)});
        check("R9 addr stable", {31'd0, addr_moved}, 32'd0);
        ack_delay = 0;
    endtask

    task automatic t_bypass;
        run(mk(6'o41, 3'd5, 1'b1, 14'h0044));
        check("R6 unchanged", {8'd0, instr_out}, {8'd0, mk(6'o41, 3'd5, 1'b1, 14'h0044)});
        check("R6 no fetch", fcount, 0);
    endtask

    task automatic t_xfer;
        run(mk(6'o05, 3'd6, 1'b1, 14'h000C));
        check("R7 fetch addr", {18'd0, flog[0]}, 32'h000C);
        check("R7 word", {8'd0, instr_out}, {8'd0, mk(6'o05, 3'd6, 1'b0, 14'h0ABC)});
    endtask

    task automatic t_hold;
        logic [23:0] w0;
        run(mk(6'o20, 3'd2, 1'b0, 14'h0100));
        w0 = instr_out;
        repeat (5) @(negedge clk);
        check("R8 done held", {31'd0, done}, 32'd1);
        check("R8 word held", {8'd0, instr_out}, {8'd0, w0});
        check("R8 flag clear", {31'd0, instr_out[14]}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        xregs[0] = 14'h0155; xregs[1] = 14'h0001; xregs[2] = 14'h0010;
        xregs[3] = 14'h3FFF; xregs[4] = 14'h0002; xregs[5] = 14'h0100;
        xregs[6] = 14'h0200; xregs[7] = 14'h0400;
        mem[6'h21] = {6'o77, 3'd0, 1'b0, 14'h0130};
        mem[6'h02] = {6'o11, 3'd5, 1'b1, 14'h0008};
        mem[6'h08] = {6'o00, 3'd2, 1'b0, 14'h0007};
        mem[6'h0C] = {6'o77, 3'd7, 1'b0, 14'h0ABC};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index();
        t_noindex();
        t_ind_single();
        t_chain();
        t_bypass();
        t_xfer();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule